// File: doc/BRIEF.md
# Folded Two-Dimensional Wavelet Transform Engine

This engine computes a multi-level two-dimensional discrete wavelet transform of a signed image held in an external synchronous memory. One low-pass and one high-pass FIR filter are shared by every pass: each level filters all rows of its region, then all columns. Both filters are downsampled by two. The smooth (average) half of each line is written to the front of the output line and the detail half to the back. Each later level works only on the top-left low-low quadrant left by the level before it.

Two word-addressed memories, A and B, hold the data and swap roles between passes. Row passes read A and write B. Column passes read B and write A. Because of this, the finished pyramid ends up whole in A. Quadrants written at earlier levels are never overwritten.

Coefficients, tap counts, sample width, image width and height and the number of levels are parameters. Each filter is a set of constant products feeding a rounded sum. The control interface is a plain start and done pair. The memory ports have no back-pressure: every read returns its word one cycle after its address is presented, and every write enable is accepted in the cycle it is high.

Top module: `wavelet2d_fold`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `a_we` and `b_we` are low.
- R2: A high `start` in the idle state begins a transform. A `start` while a transform is running is ignored: the written results are unchanged and only one `done` pulse follows.
- R3: For a line x of length N, output pair k (0 <= k < N/2) is computed at centre n = 2k. Each branch forms sum over t of c[t]*x[n+t-(T-1)/2], where T is that branch's tap count, and any sample index outside 0..N-1 reads as zero.
- R4: The low-pass value of pair k is written to position k of the output line, and the high-pass value to position N/2+k.
- R5: Each sum s is reduced as (s + 2^(FRAC-1)) shifted right arithmetically by FRAC. The result keeps its low DW bits as a two's-complement sample (wrapping, no saturation).
- R6: For level l = 0..LEVELS-1, a row pass is followed by a column pass over the region of (W>>l) columns by (H>>l) rows at the top-left. The word address of row r, column c is r*W + c.
- R7: Row passes read memory A and write memory B. Column passes read B and write A. Locations outside the region a pass writes keep their contents, so the final pyramid is complete in A.
- R8: At most one memory word is written per cycle. Lines are written in ascending order, and within a line pairs are written in ascending k. Each pair writes its low-pass value in one cycle and its high-pass value in the next.
- R9: Taking the edge that samples `start` as edge 0, the first write enable is high in the cycle ending at edge 5 + (LMAX-1)/2. LMAX is the larger tap count, which gives edge 7 with the default parameters.
- R10: `done` is high for exactly one cycle, the cycle right after the final write of the last column pass. The block is then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transform when idle |
| done | output | 1 | One-cycle completion pulse |
| a_addr | output | AW | Memory A word address |
| a_we | output | 1 | Memory A write enable |
| a_wdata | output | DW | Memory A write data |
| a_rdata | input | DW | Memory A read data, one cycle after address |
| b_addr | output | AW | Memory B word address |
| b_we | output | 1 | Memory B write enable |
| b_wdata | output | DW | Memory B write data |
| b_rdata | input | DW | Memory B read data, one cycle after address |

## Verification
A sample read in cycle c contributes to results written four cycles later (LP) and five cycles later (HP). The first write therefore falls in the cycle ending at edge 5 + (LMAX-1)/2 after start, and `done` falls in the cycle right after the last write.

The bench samples on the falling edge and counts rising edges from the start edge. This lets it compare the first-write cycle and the done cycle against those exact numbers. It does not wait for a write at an assumed time. Instead, each write is taken from the expected queue in the cycle it appears, and its memory, address and value are compared there. This checks the order of writes without tying them to fixed cycles.

// File: rtl/wavelet2d_pkg.sv
package wavelet2d_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_DONE} fold_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/wavelet2d_addr.sv
module wavelet2d_addr #(
  parameter int W  = 16,
  parameter int IW = 6,
  parameter int AW = 7
) (
  input  logic          col,
  input  logic [IW-1:0] line,
  input  logic [IW-1:0] pos,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] row_i, col_i;
  // Row pass: line is the row. Column pass: line is the column.
  always_comb begin
    row_i = col ? AW'(pos) : AW'(line);
    col_i = col ? AW'(line) : AW'(pos);
    addr  = row_i * AW'(W) + col_i;
  end
endmodule

// File: rtl/wavelet2d_window.sv
module wavelet2d_window #(
  parameter int DW  = 12,
  parameter int LEN = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  logic                 clear,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] win [LEN]
);
  // win[m] holds the sample m positions older than the newest one.
  // clear starts a new line: older slots fill with zeros (left padding).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < LEN; m++) win[m] <= '0;
    end else if (shift) begin
      win[0] <= din;
      for (int m = 1; m < LEN; m++) win[m] <= clear ? '0 : win[m-1];
    end
  end
endmodule

// File: rtl/wavelet2d_fir.sv
module wavelet2d_fir #(
  parameter int DW   = 12,
  parameter int CW   = 12,
  parameter int FRAC = 3,
  parameter int TAPS = 5,
  parameter int signed COEF [TAPS] = '{default: 0}
) (
  input  logic                 clk,
  input  logic signed [DW-1:0] win [TAPS],
  output logic signed [DW-1:0] y
);
  localparam int PW = DW + CW;
  localparam int SW = PW + $clog2(TAPS) + 1;
  localparam logic signed [SW-1:0] RND = SW'(1) <<< (FRAC - 1);

  logic signed [PW-1:0] prod [TAPS];
  logic signed [SW-1:0] acc;

  // Stage 1: constant products, one per tap.
  always_ff @(posedge clk) begin
    for (int t = 0; t < TAPS; t++)
      prod[t] <= PW'(win[t]) * PW'(CW'(COEF[t]));
  end

  // Stage 2: rounded sum, wrapped back to sample width.
  always_comb begin
    acc = RND;
    for (int t = 0; t < TAPS; t++) acc = acc + SW'(prod[t]);
  end

  always_ff @(posedge clk) y <= DW'(acc >>> FRAC);
endmodule

// File: rtl/wavelet2d_fold.sv
module wavelet2d_fold
  import wavelet2d_pkg::*;
#(
  parameter int DW      = 12,
  parameter int CW      = 12,
  parameter int FRAC    = 3,
  parameter int W       = 16,
  parameter int H       = 8,
  parameter int LEVELS  = 3,
  parameter int LP_TAPS = 5,
  parameter int HP_TAPS = 3,
  parameter int signed LP_COEF [LP_TAPS] = '{-1, 2, 6, 2, -1},
  parameter int signed HP_COEF [HP_TAPS] = '{-4, 8, -4},
  parameter int AW      = $clog2(W * H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic [AW-1:0] a_addr,
  output logic          a_we,
  output logic [DW-1:0] a_wdata,
  input  logic [DW-1:0] a_rdata,
  output logic [AW-1:0] b_addr,
  output logic          b_we,
  output logic [DW-1:0] b_wdata,
  input  logic [DW-1:0] b_rdata
);
  localparam int LMAX = imax(LP_TAPS, HP_TAPS);
  localparam int C    = (LMAX - 1) / 2;
  localparam int IW   = $clog2(imax(W, H) + LMAX) + 1;
  localparam int LVW  = $clog2(LEVELS) + 1;

  typedef struct packed {
    logic          vld;
    logic          real_s;
    logic          first;
    logic          emit;
    logic [IW-1:0] line;
    logic [IW-1:0] k;
  } rtok_t;

  typedef struct packed {
    logic          emit;
    logic [IW-1:0] line;
    logic [IW-1:0] k;
  } wtok_t;

  fold_state_e   st;
  logic [LVW-1:0] lev;
  logic          col;
  logic [IW-1:0] line, j;
  logic [1:0]    dcnt;
  logic [IW-1:0] wl, hl, nlen, nlines, half, jc, rd_pos;
  logic          issue, rd_real;
  rtok_t         tok0, tok1;
  wtok_t         tok2, tok3, tok4;
  logic [AW-1:0] rd_addr, wr_addr;

  // Size of the current line and pass.
  always_comb begin
    wl     = IW'(W) >> lev;
    hl     = IW'(H) >> lev;
    nlen   = col ? hl : wl;
    nlines = col ? wl : hl;
    half   = nlen >> 1;
    jc     = j - IW'(C);
  end

  // Issue stage: one read slot per cycle. The last C slots of a line feed zeros (right padding).
  always_comb begin
    issue       = (st == ST_RUN);
    rd_real     = (j < nlen);
    rd_pos      = rd_real ? j : '0;
    tok0.vld    = issue;
    tok0.real_s = issue && rd_real;
    tok0.first  = issue && (j == '0);
    tok0.emit   = issue && (j >= IW'(C)) && !jc[0];
    tok0.line   = line;
    tok0.k      = jc >> 1;
  end

  wavelet2d_addr #(.W(W), .IW(IW), .AW(AW)) u_rd_addr (
    .col(col), .line(line), .pos(rd_pos), .addr(rd_addr)
  );

  // Pass sequencer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      lev  <= '0;
      col  <= 1'b0;
      line <= '0;
      j    <= '0;
      dcnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st   <= ST_RUN;
          lev  <= '0;
          col  <= 1'b0;
          line <= '0;
          j    <= '0;
        end
        ST_RUN: begin
          if (j == nlen - IW'(1) + IW'(C)) begin
            j <= '0;
            if (line == nlines - IW'(1)) begin
              line <= '0;
              dcnt <= '0;
              st   <= ST_DRAIN;
            end else begin
              line <= line + IW'(1);
            end
          end else begin
            j <= j + IW'(1);
          end
        end
        ST_DRAIN: begin
          dcnt <= dcnt + 2'd1;
          if (dcnt == 2'd3) begin
            if (col && (lev == LVW'(LEVELS - 1))) begin
              st <= ST_DONE;
            end else begin
              st <= ST_RUN;
              if (col) lev <= lev + LVW'(1);
              col <= !col;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Sample window and the two filters. Both branches share one window, so their outputs are aligned.
  logic signed [DW-1:0] din, y_lp, y_hp;
  logic signed [DW-1:0] win    [LMAX];
  logic signed [DW-1:0] lp_win [LP_TAPS];
  logic signed [DW-1:0] hp_win [HP_TAPS];

  assign din = tok1.real_s ? $signed(col ? b_rdata : a_rdata) : '0;

  wavelet2d_window #(.DW(DW), .LEN(LMAX)) u_win (
    .clk(clk), .rst_n(rst_n), .shift(tok1.vld), .clear(tok1.first), .din(din), .win(win)
  );

  for (genvar t = 0; t < LP_TAPS; t++) begin : g_lp_tap
    assign lp_win[t] = win[C - t + (LP_TAPS - 1) / 2];
  end
  for (genvar t = 0; t < HP_TAPS; t++) begin : g_hp_tap
    assign hp_win[t] = win[C - t + (HP_TAPS - 1) / 2];
  end

  wavelet2d_fir #(.DW(DW), .CW(CW), .FRAC(FRAC), .TAPS(LP_TAPS), .COEF(LP_COEF)) u_lp_fir (
    .clk(clk), .win(lp_win), .y(y_lp)
  );
  wavelet2d_fir #(.DW(DW), .CW(CW), .FRAC(FRAC), .TAPS(HP_TAPS), .COEF(HP_COEF)) u_hp_fir (
    .clk(clk), .win(hp_win), .y(y_hp)
  );

  // Token pipeline matched to data: read, window, products, sum.
  logic                 hold_vld;
  logic [IW-1:0]        hold_pos, hold_line;
  logic signed [DW-1:0] hold_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok1     <= '0;
      tok2     <= '0;
      tok3     <= '0;
      tok4     <= '0;
      hold_vld <= 1'b0;
    end else begin
      tok1     <= tok0;
      tok2     <= '{emit: tok1.emit, line: tok1.line, k: tok1.k};
      tok3     <= tok2;
      tok4     <= tok3;
      hold_vld <= tok4.emit;
    end
  end

  always_ff @(posedge clk) begin
    hold_pos  <= half + tok4.k;
    hold_line <= tok4.line;
    hold_data <= y_hp;
  end

  // Output routing: LP now, HP from the hold register in the next cycle.
  logic                 wr_en;
  logic [IW-1:0]        wr_pos, wr_line;
  logic signed [DW-1:0] wr_data;

  always_comb begin
    wr_en   = tok4.emit || hold_vld;
    wr_pos  = hold_vld ? hold_pos  : tok4.k;
    wr_line = hold_vld ? hold_line : tok4.line;
    wr_data = hold_vld ? hold_data : y_lp;
  end

  wavelet2d_addr #(.W(W), .IW(IW), .AW(AW)) u_wr_addr (
    .col(col), .line(wr_line), .pos(wr_pos), .addr(wr_addr)
  );

  // Memory role swap: row passes read A and write B; column passes do the reverse.
  always_comb begin
    a_addr  = col ? wr_addr : rd_addr;
    a_we    = col && wr_en;
    a_wdata = wr_data;
    b_addr  = col ? rd_addr : wr_addr;
    b_we    = !col && wr_en;
    b_wdata = wr_data;
    done    = (st == ST_DONE);
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle");

  assert_done_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(hold_vld)) else $error("done not right after final write");

  assert_no_write_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld |-> !tok4.emit) else $error("LP and HP writes collide");

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !(a_we || b_we)) else $error("write while idle");
endmodule

// File: tb/wavelet2d_fold_tb.sv
module wavelet2d_fold_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12, FRAC = 3, W = 16, H = 8, LEVELS = 3, AW = 7;
  localparam int NW = W * H;
  localparam int LPT = 5, HPT = 3, C = 2;
  localparam int LPC [LPT] = '{-1, 2, 6, 2, -1};
  localparam int HPC [HPT] = '{-4, 8, -4};

  logic clk = 1'b0, rst_n, start;
  logic done, a_we, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wavelet2d_fold u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  // Synchronous memories, one-cycle read latency.
  logic [DW-1:0] mem_a [NW];
  logic [DW-1:0] mem_b [NW];
  always @(posedge clk) begin
    if (a_we) mem_a[a_addr] <= a_wdata;
    if (b_we) mem_b[b_addr] <= b_wdata;
    a_rdata <= mem_a[a_addr];
    b_rdata <= mem_b[b_addr];
  end

  int checks = 0, failures = 0, tick = 0;
  int first_wr, last_wr, done_cnt, t0;
  always @(posedge clk) tick <= tick + 1;

  typedef struct {int mem; int addr; int data;} exp_t;
  exp_t q[$];
  int ref_m [2][NW];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int wrap(int v);
    logic signed [DW-1:0] t;
    t = DW'(v);
    return int'(t);
  endfunction

  function automatic int maddr(int col, int ln, int pos);
    return col ? pos * W + ln : ln * W + pos;
  endfunction

  function automatic int sample(int s, int col, int ln, int i, int len);
    if (i < 0 || i >= len) return 0;
    return ref_m[s][maddr(col, ln, i)];
  endfunction

  // Reference model (R3..R8): pushes every expected write in order.
  task automatic build_expect();
    for (int lev = 0; lev < LEVELS; lev++) begin
      for (int col = 0; col < 2; col++) begin
        int len, nl, s, d;
        len = col ? (H >> lev) : (W >> lev);
        nl  = col ? (W >> lev) : (H >> lev);
        s = col; d = 1 - col;
        for (int ln = 0; ln < nl; ln++) begin
          for (int k = 0; k < len / 2; k++) begin
            int lp, hp, a0, a1;
            lp = 0; hp = 0;
            for (int t = 0; t < LPT; t++) lp += LPC[t] * sample(s, col, ln, 2*k + t - (LPT-1)/2, len);
            for (int t = 0; t < HPT; t++) hp += HPC[t] * sample(s, col, ln, 2*k + t - (HPT-1)/2, len);
            lp = wrap((lp + (1 << (FRAC-1))) >>> FRAC);
            hp = wrap((hp + (1 << (FRAC-1))) >>> FRAC);
            a0 = maddr(col, ln, k);
            a1 = maddr(col, ln, len/2 + k);
            q.push_back('{d, a0, lp});
            q.push_back('{d, a1, hp});
            ref_m[d][a0] = lp;
            ref_m[d][a1] = hp;
          end
        end
      end
    end
  endtask

  // Monitor: pops the scoreboard on every write and checks the done timing.
  always @(negedge clk) begin
    if (rst_n) begin
      if (a_we || b_we) begin
        int m, ad, dv;
        exp_t e;
        m  = a_we ? 0 : 1;
        ad = a_we ? int'(a_addr) : int'(b_addr);
        dv = int'($signed(a_we ? a_wdata : b_wdata));
        if (first_wr < 0) first_wr = tick;
        last_wr = tick;
        check(!(a_we && b_we), "R8", "two writes in one cycle", 2, 1);
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected write addr", ad, -1);
        end else begin
          e = q.pop_front();
          check(m == e.mem, "R7", "target memory", m, e.mem);
          check(ad == e.addr, "R4 R8", "write address", ad, e.addr);
          check(dv == e.data, "R3 R5", "write data", dv, e.data);
        end
      end
      if (done) begin
        done_cnt++;
        check(last_wr == tick - 1, "R10", "done cycle vs last write", tick - 1 - last_wr, 0);
      end
    end
  end

  task automatic load(int pat);
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        int v;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (pat)
          0: v = r * 37 - c * 11 + 5;
          1: v = int'($signed(lf[11:0]));
          default: v = ((r + c) % 2) ? 2047 : -2048;
        endcase
        mem_a[r*W + c] = DW'(v);
        mem_b[r*W + c] = '0;
        ref_m[0][r*W + c] = wrap(v);
        ref_m[1][r*W + c] = 0;
      end
    end
  endtask

  task automatic run_image(int pat, bit poke);
    int bad_a, bad_b;
    load(pat);
    q.delete();
    build_expect();
    first_wr = -1; last_wr = -1; done_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    t0 = tick;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R2: start during a run must be ignored
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(done_cnt == 1, "R2 R10", "done pulses", done_cnt, 1);
    check(q.size() == 0, "R6", "writes missing", q.size(), 0);
    check(first_wr - t0 == 5 + C, "R9", "first write cycle", first_wr - t0, 5 + C);
    check(!a_we && !b_we, "R10", "idle after done", int'(a_we) + int'(b_we), 0);
    bad_a = 0; bad_b = 0;
    for (int i = 0; i < NW; i++) begin
      if (int'($signed(mem_a[i])) != ref_m[0][i]) bad_a++;
      if (int'($signed(mem_b[i])) != ref_m[1][i]) bad_b++;
    end
    check(bad_a == 0, "R7", "final memory A mismatches", bad_a, 0);
    check(bad_b == 0, "R7", "final memory B mismatches", bad_b, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(!done, "R1", "done in reset", int'(done), 0);
    check(!a_we && !b_we, "R1", "write enables in reset", int'(a_we) + int'(b_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !a_we && !b_we, "R1", "outputs after reset", int'(done) + int'(a_we) + int'(b_we), 0);
    run_image(0, 1'b0);
    run_image(1, 1'b1);
    run_image(2, 1'b0);
    summary();
    $finish;
  end
endmodule